// File: doc/BRIEF.md
# Delayed Pulse Generator

The block produces timed pulse cycles from a single clock. Each cycle opens with a one-clock trigger marker on `trig_out`. A positive pulse on `pulse_p` follows at a programmed offset and lasts a programmed number of clocks. `pulse_n` carries the same timing with inverted polarity. Period, delay and width are all counted in clock cycles.

A cycle can be started in three ways. The internal repetition timer restarts cycles back to back. A rising edge on the external trigger line can start a cycle, and so can a rising edge on the manual single-shot line. Double mode adds a leading pulse that begins with the marker. Gated mode lets cycles start only while the gate input is high. The configuration is captured when a cycle starts. A pulse that would run past the end of its cycle is cut short and raises a flag.

Top module: `pdg_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `trig_out`, `pulse_p` and `trunc_err` are low and `pulse_n` is high.
- R2: A cycle starts on the clock edge at which a start condition is sampled. `trig_out` is high for exactly the first clock of the cycle (cycle offset 0) and low for the rest of it.
- R3: In single mode (`cfg_double`=0), `pulse_p` is high at cycle offsets `cfg_delay` to `cfg_delay+cfg_width-1` and low at every other offset.
- R4: `cfg_src` selects the start source. 0 is the internal timer. 1 is a rising edge of `ext_trig`. 2 is a rising edge of `man_shot`. 3 starts nothing. An edge on a source that is not selected starts no cycle.
- R5: `pulse_n` is always the inverse of `pulse_p`.
- R6: In double mode (`cfg_double`=1), `pulse_p` is high at offsets 0 to `cfg_width-1` and again at offsets `cfg_delay` to `cfg_delay+cfg_width-1`.
- R7: A cycle lasts `cfg_period` clocks, and `pulse_p` is low outside a cycle. At each cycle start, `trunc_err` loads 1 if `cfg_delay+cfg_width >= cfg_period` and 0 otherwise. It holds that value until the next cycle start.
- R8: A rising edge on `ext_trig` or `man_shot` that arrives while a cycle is in progress, including its last clock, is ignored and is not remembered.
- R9: With the internal source, a new cycle starts on the clock right after the previous cycle ends, with no idle clock. If the source is changed during a cycle, that cycle still completes.
- R10: With `cfg_gated`=1, a cycle can start only while `gate_in` is high. Lowering `gate_in` during a cycle lets that cycle complete.
- R11: Period, delay, width and mode are captured at cycle start. A change to them during a cycle takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | 2 | Start source: 0 internal, 1 external, 2 manual, 3 none |
| cfg_gated | input | 1 | Gated operation enable |
| cfg_double | input | 1 | Double pulse mode |
| cfg_period | input | CNT_W | Cycle length in clocks |
| cfg_delay | input | CNT_W | Pulse offset from the marker, in clocks |
| cfg_width | input | CNT_W | Pulse width in clocks |
| gate_in | input | 1 | Gate level for gated operation |
| ext_trig | input | 1 | External trigger, rising-edge sensitive |
| man_shot | input | 1 | Manual single shot, rising-edge sensitive |
| trig_out | output | 1 | One-clock marker at each cycle start |
| pulse_p | output | 1 | Positive output pulse |
| pulse_n | output | 1 | Inverted output pulse |
| trunc_err | output | 1 | Pulse of the current cycle was truncated |

## Verification
The bench sends a second external edge into a running cycle and also edits the delay mid-cycle. A design that remembered the edge would fire an extra marker after the cycle. A design that read the live configuration would shift the pulse that is already scheduled. Free-running and gated runs are stopped during their last cycle. A design that cut the cycle short, or added an idle clock between cycles, would misplace the markers. A truncating setting is followed by a clean one, which catches a flag that sticks or one that never sets. Double mode is checked, as is an edge on the source that is not selected.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_EXT = 2'd1,
        SRC_MAN = 2'd2,
        SRC_OFF = 2'd3
    } src_e;

    // offset t inside the half-open window [s, s+w)
    function automatic logic in_win(input logic [31:0] t,
                                    input logic [31:0] s,
                                    input logic [31:0] w);
        logic [32:0] e;
        e = {1'b0, s} + {1'b0, w};
        return (t >= s) && ({1'b0, t} < e);
    endfunction

    // delay plus width reaching the period means truncation
    function automatic logic overruns(input logic [31:0] d,
                                      input logic [31:0] w,
                                      input logic [31:0] p);
        logic [32:0] e;
        e = {1'b0, d} + {1'b0, w};
        return e >= {1'b0, p};
    endfunction

endpackage

// File: rtl/pdg_trig_sel.sv
module pdg_trig_sel
    import pdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src,
    input  logic       gated,
    input  logic       gate_in,
    input  logic       ext_trig,
    input  logic       man_shot,
    input  logic       busy,
    input  logic       last,
    output logic       start
);
    logic ext_q, man_q, ext_rise, man_rise, gate_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
            man_q <= 1'b0;
        end else begin
            ext_q <= ext_trig;
            man_q <= man_shot;
        end
    end

    assign ext_rise = ext_trig & ~ext_q;
    assign man_rise = man_shot & ~man_q;
    assign gate_ok  = ~gated | gate_in;

    always_comb begin
        start = 1'b0;
        unique case (src_e'(src))
            SRC_INT: start = ~busy | last;
            SRC_EXT: start = ext_rise & ~busy;
            SRC_MAN: start = man_rise & ~busy;
            SRC_OFF: start = 1'b0;
        endcase
        start = start & gate_ok;
    end

    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (gated && !gate_in) |-> !start); // R10

    AST_NO_MIDCYCLE_START: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |-> !start); // R8
endmodule

// File: rtl/pdg_timer.sv
module pdg_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             cfg_double,
    output logic             busy,
    output logic             last,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] dly_q,
    output logic [CNT_W-1:0] wid_q,
    output logic             dbl_q
);
    localparam int EW = CNT_W + 1;

    logic [EW-1:0] next_off;

    assign next_off = {1'b0, cnt} + EW'(1);
    assign last     = busy && (next_off >= {1'b0, per_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            per_q <= '0;
            dly_q <= '0;
            wid_q <= '0;
            dbl_q <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            per_q <= cfg_period;
            dly_q <= cfg_delay;
            wid_q <= cfg_width;
            dbl_q <= cfg_double;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    AST_OFFSET_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (busy && !last && !start) |=> (busy && cnt == $past(cnt) + CNT_W'(1))); // R3

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> ($stable(per_q) && $stable(dly_q) && $stable(wid_q) && $stable(dbl_q))); // R11

    AST_CYCLE_ENDS: assert property (@(posedge clk) disable iff (rst)
        (last && !start) |=> !busy); // R7
endmodule

// File: rtl/pdg_shaper.sv
module pdg_shaper
    import pdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             busy,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per_q,
    input  logic [CNT_W-1:0] dly_q,
    input  logic [CNT_W-1:0] wid_q,
    input  logic             dbl_q,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_width,
    output logic             trig_out,
    output logic             pulse_p,
    output logic             pulse_n,
    output logic             trunc_err
);
    logic main_win, lead_win;

    assign main_win = in_win(32'(cnt), 32'(dly_q), 32'(wid_q));
    assign lead_win = dbl_q && in_win(32'(cnt), 32'd0, 32'(wid_q));

    assign trig_out = busy && (cnt == '0);
    assign pulse_p  = busy && (main_win || lead_win);
    assign pulse_n  = ~pulse_p;

    always_ff @(posedge clk) begin
        if (rst)
            trunc_err <= 1'b0;
        else if (start)
            trunc_err <= overruns(32'(cfg_delay), 32'(cfg_width), 32'(cfg_period));
    end

    AST_MARKER_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        (trig_out && per_q > CNT_W'(1)) |=> !trig_out); // R2

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(trunc_err)); // R7

    AST_PULSE_INSIDE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pulse_p |-> (busy && cnt < per_q || per_q <= CNT_W'(1))); // R7
endmodule

// File: rtl/pdg_top.sv
module pdg_top #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_src,
    input  logic             cfg_gated,
    input  logic             cfg_double,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             gate_in,
    input  logic             ext_trig,
    input  logic             man_shot,
    output logic             trig_out,
    output logic             pulse_p,
    output logic             pulse_n,
    output logic             trunc_err
);
    logic             start, busy, last, dbl_q;
    logic [CNT_W-1:0] cnt, per_q, dly_q, wid_q;

    pdg_trig_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .src      (cfg_src),
        .gated    (cfg_gated),
        .gate_in  (gate_in),
        .ext_trig (ext_trig),
        .man_shot (man_shot),
        .busy     (busy),
        .last     (last),
        .start    (start)
    );

    pdg_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg_period (cfg_period),
        .cfg_delay  (cfg_delay),
        .cfg_width  (cfg_width),
        .cfg_double (cfg_double),
        .busy       (busy),
        .last       (last),
        .cnt        (cnt),
        .per_q      (per_q),
        .dly_q      (dly_q),
        .wid_q      (wid_q),
        .dbl_q      (dbl_q)
    );

    pdg_shaper #(.CNT_W(CNT_W)) u_shp (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .busy       (busy),
        .cnt        (cnt),
        .per_q      (per_q),
        .dly_q      (dly_q),
        .wid_q      (wid_q),
        .dbl_q      (dbl_q),
        .cfg_period (cfg_period),
        .cfg_delay  (cfg_delay),
        .cfg_width  (cfg_width),
        .trig_out   (trig_out),
        .pulse_p    (pulse_p),
        .pulse_n    (pulse_n),
        .trunc_err  (trunc_err)
    );

    AST_FIRST_CLK_MARKED: assert property (@(posedge clk) disable iff (rst)
        start |=> trig_out); // R2
endmodule

// File: tb/tb_pdg_top.sv
`timescale 1ns/1ps
module tb_pdg_top;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cfg_src = 2'd3;
    logic             cfg_gated = 1'b0, cfg_double = 1'b0;
    logic [CNT_W-1:0] cfg_period = '0, cfg_delay = '0, cfg_width = '0;
    logic             gate_in = 1'b0, ext_trig = 1'b0, man_shot = 1'b0;
    logic             trig_out, pulse_p, pulse_n, trunc_err;

    typedef struct {
        bit    trig;
        bit    pul;
        bit    err;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    cur_err = 1'b0;

    always #2.5 clk = ~clk;

    pdg_top #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_gated(cfg_gated),
        .cfg_double(cfg_double), .cfg_period(cfg_period), .cfg_delay(cfg_delay),
        .cfg_width(cfg_width), .gate_in(gate_in), .ext_trig(ext_trig),
        .man_shot(man_shot), .trig_out(trig_out), .pulse_p(pulse_p),
        .pulse_n(pulse_n), .trunc_err(trunc_err)
    );

    task automatic push_cycle(input int p, input int d, input int w,
                              input bit dbl, input string tag);
        cur_err = (d + w >= p);
        for (int t = 0; t < p; t++) begin
            item_t it;
            it.trig = (t == 0);
            it.pul  = (t >= d && t < d + w) || (dbl && t < w);
            it.err  = cur_err;
            it.tag  = tag;
            exp_q.push_back(it);
        end
    endtask

    task automatic push_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.trig = 1'b0;
            it.pul  = 1'b0;
            it.err  = cur_err;
            it.tag  = tag;
            exp_q.push_back(it);
        end
    endtask

    task automatic set_cfg(input int p, input int d, input int w, input bit dbl);
        @(negedge clk);
        cfg_period = CNT_W'(p);
        cfg_delay  = CNT_W'(d);
        cfg_width  = CNT_W'(w);
        cfg_double = dbl;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
    endtask

    task automatic ext_cycle(input int p, input int d, input int w,
                             input bit dbl, input string tag);
        @(negedge clk);
        ext_trig = 1'b1;
        push_cycle(p, d, w, dbl, tag);
        push_idle(1, tag);
        @(negedge clk);
        ext_trig = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // monitor: compare outputs against the scoreboard, 2 ns after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (trig_out !== it.trig || pulse_p !== it.pul ||
                pulse_n !== !it.pul || trunc_err !== it.err) begin
                fails++;
                $display("FAIL %s: trig/p/n/err got %b%b%b%b expected %b%b%b%b",
                         it.tag, trig_out, pulse_p, pulse_n, trunc_err,
                         it.trig, it.pul, !it.pul, it.err);
            end
        end
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (trig_out !== 1'b0 || pulse_p !== 1'b0 || pulse_n !== 1'b1 || trunc_err !== 1'b0) begin
            fails++;
            $display("FAIL R1: trig/p/n/err got %b%b%b%b expected 0010",
                     trig_out, pulse_p, pulse_n, trunc_err);
        end
        @(negedge clk);
        rst = 1'b0;
        cfg_src = 2'd1;
        push_idle(2, "R1 R5");
        drain();

        // single pulse from an external edge
        set_cfg(10, 3, 2, 1'b0);
        ext_cycle(10, 3, 2, 1'b0, "R2 R3 R5");
        drain();

        // double pulse
        set_cfg(12, 5, 2, 1'b1);
        ext_cycle(12, 5, 2, 1'b1, "R6");
        drain();

        // truncation sets the flag, the flag then holds
        set_cfg(8, 5, 6, 1'b0);
        ext_cycle(8, 5, 6, 1'b0, "R7");
        push_idle(3, "R7 hold");
        drain();

        // clean cycle clears the flag
        set_cfg(10, 3, 2, 1'b0);
        ext_cycle(10, 3, 2, 1'b0, "R7 clear");
        drain();

        // second edge and delay edit mid-cycle are ignored
        ext_cycle(10, 3, 2, 1'b0, "R8 R11");
        push_idle(3, "R8");
        repeat (2) @(negedge clk);
        ext_trig  = 1'b1;
        cfg_delay = CNT_W'(6);
        @(negedge clk);
        ext_trig = 1'b0;
        drain();
        ext_cycle(10, 6, 2, 1'b0, "R11");
        drain();

        // manual source: external edge ignored, manual edge starts a cycle
        @(negedge clk);
        cfg_src = 2'd2;
        @(negedge clk);
        ext_trig = 1'b1;
        push_idle(4, "R4");
        @(negedge clk);
        ext_trig = 1'b0;
        drain();
        @(negedge clk);
        man_shot = 1'b1;
        push_cycle(10, 6, 2, 1'b0, "R4");
        push_idle(1, "R4");
        @(negedge clk);
        man_shot = 1'b0;
        drain();

        // internal free run, stopped during the third cycle
        set_cfg(6, 2, 1, 1'b0);
        @(negedge clk);
        cfg_src = 2'd0;
        for (int k = 0; k < 3; k++) push_cycle(6, 2, 1, 1'b0, "R9");
        push_idle(2, "R9");
        repeat (3 * 6 - 1) @(negedge clk);
        cfg_src = 2'd3;
        drain();

        // gated internal: gate low blocks, gate high runs, lowered mid-cycle
        @(negedge clk);
        cfg_gated = 1'b1;
        gate_in   = 1'b0;
        cfg_src   = 2'd0;
        push_idle(5, "R10");
        drain();
        @(negedge clk);
        gate_in = 1'b1;
        for (int k = 0; k < 2; k++) push_cycle(6, 2, 1, 1'b0, "R10");
        push_idle(2, "R10");
        repeat (2 * 6 - 1) @(negedge clk);
        gate_in = 1'b0;
        drain();

        // gated external with the gate low
        @(negedge clk);
        cfg_src = 2'd1;
        @(negedge clk);
        ext_trig = 1'b1;
        push_idle(4, "R10");
        @(negedge clk);
        ext_trig = 1'b0;
        drain();

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule